// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data ports, A and B, and passes words between them in either direction. Each port owns a holding register that captures the words present on that port whenever its own strobe rises. The strobe is sampled in the system clock domain. Each outgoing path has its own source select: the live word from the opposite port, or the word held in the opposite port's register.

An active-low enable and a direction input decide which port, if either, is driven. Each bidirectional bus is split into separate input, output and output-enable signals, so that a pad ring or a tri-state wrapper can join them outside this block. Captures happen on every strobe edge, whatever the enable and direction inputs are doing. A chip can therefore park a word in a register while the buses are isolated and drive it out later.

Top module: `registered_bus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both holding registers to zero. After reset, selecting the held source on either path drives zero.
- R2: The port-A holding register loads `a_in` on the clock edge at which `a_strobe` is sampled high after being sampled low. It keeps its value on every other edge.
- R3: The port-B holding register loads `b_in` on the clock edge at which `b_strobe` is sampled high after being sampled low. It keeps its value on every other edge.
- R4: Captures into either register take place whatever the values of `en_n` and `a_to_b`, including while both ports are isolated.
- R5: While `en_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: While `en_n` is 0, `a_to_b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `a_to_b` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R7: With `b_src_held` = 0, `b_out` equals the live `a_in`. With `a_src_held` = 0, `a_out` equals the live `b_in`.
- R8: With `b_src_held` = 1, `b_out` equals the port-A holding register.
- R9: With `a_src_held` = 1, `a_out` equals the port-B holding register.
- R10: In held mode, a word captured by a strobe edge appears on the driven output right after the clock edge that loads it. Capture and forward therefore take a single operation.
- R11: The paths are independent. `a_strobe`, `a_in` capture and `b_src_held` never change `a_out`, and `b_strobe` and `a_src_held` never change `b_out`.
- R12: Output words and enables follow changes on `en_n`, `a_to_b`, `a_src_held`, `b_src_held` and the live inputs combinationally, with no clock edge needed.
- R13: A strobe held high over several clock edges loads its register only once, on the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low output enable for both ports |
| a_to_b | input | 1 | 1: drive port B, 0: drive port A |
| b_src_held | input | 1 | Source for port B: 0 live A word, 1 held A word |
| a_src_held | input | 1 | Source for port A: 0 live B word, 1 held B word |
| a_strobe | input | 1 | Capture strobe of the port-A register |
| b_strobe | input | 1 | Capture strobe of the port-B register |
| a_in | input | WIDTH | Word arriving at port A |
| a_out | output | WIDTH | Word to drive onto port A |
| a_oe | output | 1 | Port A output enable |
| b_in | input | WIDTH | Word arriving at port B |
| b_out | output | WIDTH | Word to drive onto port B |
| b_oe | output | 1 | Port B output enable |

## Verification
The bench builds the block with WIDTH = 4, so that each word has only sixteen values. With that width it can try every pair of live words under every combination of enable, direction and both source selects, which gives 4096 combinational cases against fixed held words. It also loads every one of the sixteen values into each register, while enable and direction vary. During each load it checks that held strobes do not reload and that the opposite path stays untouched.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int N_PORTS = 2;
    localparam int PORT_A  = 0;
    localparam int PORT_B  = 1;

    typedef enum logic [1:0] {
        DRIVE_NONE = 2'b00,
        DRIVE_A    = 2'b01,
        DRIVE_B    = 2'b10
    } drive_e;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    typedef struct packed {
        logic en_n;
        logic a_to_b;
        src_e src_to_b;
        src_e src_to_a;
    } ctrl_t;

    function automatic drive_e decode_drive(input logic en_n, input logic a_to_b);
        if (en_n)
            return DRIVE_NONE;
        else if (a_to_b)
            return DRIVE_B;
        else
            return DRIVE_A;
    endfunction

endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= strobe;
    end

    assign rise = strobe & ~prev_q;

    // R13: a held strobe gives a single load pulse
    p_one_shot_r13: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2 / R3: value kept when not loading
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    // R2 / R3: loaded value is the sampled input
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] a_live,
    input  logic [WIDTH-1:0] b_live,
    input  logic [WIDTH-1:0] a_held,
    input  logic [WIDTH-1:0] b_held,
    output logic [WIDTH-1:0] a_word,
    output logic [WIDTH-1:0] b_word,
    output logic             a_drive,
    output logic             b_drive
);
    drive_e side;

    always_comb begin
        side    = decode_drive(ctrl.en_n, ctrl.a_to_b);
        a_drive = (side == DRIVE_A);
        b_drive = (side == DRIVE_B);
        b_word  = (ctrl.src_to_b == SRC_HELD) ? a_held : a_live;
        a_word  = (ctrl.src_to_a == SRC_HELD) ? b_held : b_live;
    end

endmodule

// File: rtl/registered_bus_xcvr.sv
module registered_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             a_to_b,
    input  logic             b_src_held,
    input  logic             a_src_held,
    input  logic             a_strobe,
    input  logic             b_strobe,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [N_PORTS-1:0]            strobe_v;
    logic [N_PORTS-1:0]            load_v;
    logic [N_PORTS-1:0][WIDTH-1:0] live_v;
    logic [N_PORTS-1:0][WIDTH-1:0] held_v;
    ctrl_t                         ctrl;

    assign strobe_v[PORT_A] = a_strobe;
    assign strobe_v[PORT_B] = b_strobe;
    assign live_v[PORT_A]   = a_in;
    assign live_v[PORT_B]   = b_in;

    assign ctrl.en_n     = en_n;
    assign ctrl.a_to_b   = a_to_b;
    assign ctrl.src_to_b = src_e'(b_src_held);
    assign ctrl.src_to_a = src_e'(a_src_held);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        xcvr_edge_detect u_edge (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe_v[p]),
            .rise   (load_v[p])
        );

        xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold (
            .clk  (clk),
            .rst  (rst),
            .load (load_v[p]),
            .d    (live_v[p]),
            .q    (held_v[p])
        );
    end

    xcvr_route #(.WIDTH(WIDTH)) u_route (
        .ctrl    (ctrl),
        .a_live  (a_in),
        .b_live  (b_in),
        .a_held  (held_v[PORT_A]),
        .b_held  (held_v[PORT_B]),
        .a_word  (a_out),
        .b_word  (b_out),
        .a_drive (a_oe),
        .b_drive (b_oe)
    );

    // R6: never both ports driven
    p_oe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_oe, b_oe}));

    // R5: isolation releases both ports
    p_isolate_r5: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (!a_oe && !b_oe));

    // R10: A word captured on a strobe rise is forwarded to B in held mode
    p_fwd_ab_r10: assert property (@(posedge clk) disable iff (rst)
        (a_strobe && !$past(a_strobe)) |=> (!b_src_held || b_out == $past(a_in)));

    // R10: B word captured on a strobe rise is forwarded to A in held mode
    p_fwd_ba_r10: assert property (@(posedge clk) disable iff (rst)
        (b_strobe && !$past(b_strobe)) |=> (!a_src_held || a_out == $past(b_in)));

endmodule

// File: tb/registered_bus_xcvr_test.sv
module registered_bus_xcvr_test;
    localparam int W = 4;
    localparam int NV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_n = 1'b1, a_to_b = 1'b0, b_src_held = 1'b0, a_src_held = 1'b0;
    logic         a_strobe = 1'b0, b_strobe = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] exp_ra = '0, exp_rb = '0;

    registered_bus_xcvr #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .en_n(en_n), .a_to_b(a_to_b),
        .b_src_held(b_src_held), .a_src_held(a_src_held),
        .a_strobe(a_strobe), .b_strobe(b_strobe),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        b_src_held = 1'b1;
        a_src_held = 1'b1;
        #1;
        check("R1 held A after reset", 8'(b_out), 8'h0);
        check("R1 held B after reset", 8'(a_out), 8'h0);

        // Loads into register A across all values, enable/direction varied (R2 R4 R10 R11 R13)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            a_in = W'(v);
            a_strobe = 1'b1;
            en_n = v[0];
            a_to_b = v[1];
            @(negedge clk);
            exp_ra = W'(v);
            check("R2 R4 R10 load A forwarded", 8'(b_out), 8'(exp_ra));
            check("R11 A path leaves a_out", 8'(a_out), 8'(exp_rb));
            a_in = ~W'(v);
            @(negedge clk);
            check("R13 held strobe A no reload", 8'(b_out), 8'(exp_ra));
            a_strobe = 1'b0;
            @(negedge clk);
            check("R2 A holds after strobe", 8'(b_out), 8'(exp_ra));
        end

        // Loads into register B (R3 R4 R10 R11 R13)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            b_in = W'(NV - 1 - v);
            b_strobe = 1'b1;
            en_n = v[1];
            a_to_b = v[0];
            @(negedge clk);
            exp_rb = W'(NV - 1 - v);
            check("R3 R4 R10 load B forwarded", 8'(a_out), 8'(exp_rb));
            check("R11 B path leaves b_out", 8'(b_out), 8'(exp_ra));
            b_in = W'(v);
            @(negedge clk);
            check("R13 held strobe B no reload", 8'(a_out), 8'(exp_rb));
            b_strobe = 1'b0;
            @(negedge clk);
            check("R3 B holds after strobe", 8'(a_out), 8'(exp_rb));
        end

        // Set known held words: A=5, B=10
        @(negedge clk);
        a_in = 4'h5; b_in = 4'hA; a_strobe = 1'b1; b_strobe = 1'b1;
        @(negedge clk);
        a_strobe = 1'b0; b_strobe = 1'b0;
        exp_ra = 4'h5; exp_rb = 4'hA;
        @(negedge clk);

        // Exhaustive combinational sweep (R5 R6 R7 R8 R9 R12)
        for (int av = 0; av < NV; av++) begin
            for (int bv = 0; bv < NV; bv++) begin
                for (int c = 0; c < 16; c++) begin
                    a_in = W'(av);
                    b_in = W'(bv);
                    en_n = c[0];
                    a_to_b = c[1];
                    b_src_held = c[2];
                    a_src_held = c[3];
                    #1;
                    check("R5 R6 R12 a_oe", 8'(a_oe), 8'(!c[0] && !c[1]));
                    check("R5 R6 R12 b_oe", 8'(b_oe), 8'(!c[0] && c[1]));
                    if (c[2])
                        check("R8 b_out held", 8'(b_out), 8'(exp_ra));
                    else
                        check("R7 b_out live", 8'(b_out), 8'(av));
                    if (c[3])
                        check("R9 a_out held", 8'(a_out), 8'(exp_rb));
                    else
                        check("R7 a_out live", 8'(a_out), 8'(bv));
                end
            end
        end

        // Held words unchanged by the sweep (no strobe edges)
        @(negedge clk);
        b_src_held = 1'b1; a_src_held = 1'b1;
        #1;
        check("R2 A unchanged after sweep", 8'(b_out), 8'(exp_ra));
        check("R3 B unchanged after sweep", 8'(a_out), 8'(exp_rb));

        // Reset clears loaded registers
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 A cleared", 8'(b_out), 8'h0);
        check("R1 B cleared", 8'(a_out), 8'h0);

        finish_run();
    end

endmodule